// File: doc/BRIEF.md
# SPI Master Pin Timing Aligner

This block sits between the shift engine of an SPI master and the pads. At high serial clock rates the round trip from the master's data output through the slave and back to the master's data input can take more than a system clock cycle, so the master samples the wrong bit. The aligner lets software retime three things independently: the outgoing data line (0 to 3 system cycles of delay), the incoming data line (0 to 3 cycles of delay) and the point at which the incoming bit is captured relative to the shift engine's nominal sampling strobe (from two cycles before it to one cycle after it).

The captured bit is presented on `rx_bit` with a one-cycle `rx_valid` pulse for every nominal strobe. The capture can move to before the nominal strobe without any look-ahead. Internally, the sampled data runs through a fixed two-cycle delay and the strobe is delayed by 0 to 3 cycles against it. The settings come from a 32-bit control word. The active copy is only refreshed while no burst is running and no strobe is still in flight, so a setting written mid-burst takes effect only once the burst has drained. Early capture is typically chosen for source clocks of 40 MHz and above. Extra input delay of 1, 2 or 3 cycles suits clock divide ratios of at least 6, 8 or 16.

Top module: `spi_io_align`

## Requirements
- R1: The outgoing-delay field sits at `ctrl_word[17:16]`. With value N (0..3) active, `mosi_pin` in any cycle equals `mosi_core` as sampled N clock edges earlier (N=0: combinational pass-through).
- R2: The incoming-delay field sits at `ctrl_word[19:18]`. With value N (0..3) active, the captured bit is taken from `miso_pin` as it was N cycles before the capture point.
- R3: The capture field sits at `ctrl_word[21:20]`, encoded 0 = two cycles ahead of the nominal strobe, 1 = one cycle ahead, 2 = at the strobe, 3 = one cycle late. For a strobe sampled at edge n, the captured bit is the delayed input line value sampled at edge n+F-2, where F is the field value.
- R4: For a strobe sampled at edge n, `rx_valid` is high in exactly the cycle following edge n+F, where F is the active capture field.
- R5: Each `cap_strobe` cycle produces exactly one `rx_valid` cycle, including back-to-back strobes. No valid appears without a strobe.
- R6: The active settings load from `ctrl_word` at an edge only when `burst_active` is low, `cap_strobe` is low and no strobe is pending. A change written while a burst runs has no effect until the burst has ended and drained.
- R7: While reset is asserted, `rx_valid` and `rx_bit` are 0, and the active settings are output delay 0, input delay 0 and capture field 2 (so `mosi_pin` follows `mosi_core`).
- R8: Bits of `ctrl_word` outside 21:16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_active | input | 1 | High while the shift engine runs a burst; freezes the settings |
| ctrl_word | input | 32 | Control word carrying the three 2-bit timing fields |
| mosi_core | input | 1 | Outgoing data from the shift engine |
| mosi_pin | output | 1 | Retimed outgoing data to the pad |
| miso_pin | input | 1 | Incoming data from the pad |
| cap_strobe | input | 1 | Nominal capture strobe from the shift engine |
| rx_bit | output | 1 | Captured incoming bit |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_bit` |

## Verification
A wrong tap or a stale setting shows up on `mosi_pin` in the very cycle it occurs, since that output is checked every cycle of a burst against the value the chosen delay predicts. A misaligned strobe line or capture register appears as `rx_valid` one or more cycles off the predicted edge, or as a valid with no matching strobe. Both show no later than three cycles after the offending strobe. A wrong data tap shows as a bit mismatch on the first strobe whose neighbouring input samples differ. Changing the control word mid-burst and running a burst with all unrelated control bits set shows any premature load or decode leak within the same burst.

// File: rtl/spi_io_align.sv
`timescale 1ns/1ps
module spi_io_align #(
  parameter int CTRL_W  = 32,
  parameter int FIELD_W = 2,
  parameter int OD_LSB  = 16,
  parameter int ID_LSB  = 18,
  parameter int CAP_LSB = 20,
  parameter logic [FIELD_W-1:0] CAP_RESET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_active,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              mosi_core,
  output logic              mosi_pin,
  input  logic              miso_pin,
  input  logic              cap_strobe,
  output logic              rx_bit,
  output logic              rx_valid
);
  localparam int DEPTH = (1 << FIELD_W) - 1;

  logic [FIELD_W-1:0] od_q, id_q, cap_q;
  logic [DEPTH-1:0]   mo_sr, mi_sr, stb_sr;
  logic [1:0]         data_dly;
  logic [DEPTH:0]     mo_taps, mi_taps, stb_taps;
  logic               mi_del, stb_pick, cfg_load;

  assign mo_taps  = {mo_sr, mosi_core};
  assign mi_taps  = {mi_sr, miso_pin};
  assign stb_taps = {stb_sr, cap_strobe};

  assign mosi_pin = mo_taps[od_q];
  assign mi_del   = mi_taps[id_q];
  assign stb_pick = stb_taps[cap_q];
  assign cfg_load = !burst_active && !cap_strobe && (stb_sr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_q     <= '0;
      id_q     <= '0;
      cap_q    <= CAP_RESET;
      mo_sr    <= '0;
      mi_sr    <= '0;
      stb_sr   <= '0;
      data_dly <= '0;
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      mo_sr    <= mo_taps[DEPTH-1:0];
      mi_sr    <= mi_taps[DEPTH-1:0];
      stb_sr   <= stb_taps[DEPTH-1:0];
      data_dly <= {data_dly[0], mi_del};
      rx_valid <= stb_pick;
      if (stb_pick) rx_bit <= data_dly[1];
      if (cfg_load) begin
        od_q  <= ctrl_word[OD_LSB  +: FIELD_W];
        id_q  <= ctrl_word[ID_LSB  +: FIELD_W];
        cap_q <= ctrl_word[CAP_LSB +: FIELD_W];
      end
    end
  end

  assert_out_delay1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q == 2'd1 && $past(od_q) == 2'd1) |-> (mosi_pin == $past(mosi_core)));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |=> $stable({od_q, id_q, cap_q}));

  assert_early_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q == 2'd0) |-> (rx_valid == $past(cap_strobe)));

  assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(cap_strobe) || $past(stb_sr != '0)));

  assert_cap_reset_R7: assert property (@(posedge clk)
    $past(!rst_n) |-> (!rx_valid && !rx_bit));
endmodule

// File: tb/spi_io_align_test.sv
`timescale 1ns/1ps
module spi_io_align_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_active = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic mosi_core = 1'b0, miso_pin = 1'b0, cap_strobe = 1'b0;
  logic mosi_pin, rx_bit, rx_valid;

  always #2.5 clk = ~clk;

  spi_io_align uut (
    .clk(clk), .rst_n(rst_n), .burst_active(burst_active), .ctrl_word(ctrl_word),
    .mosi_core(mosi_core), .mosi_pin(mosi_pin), .miso_pin(miso_pin),
    .cap_strobe(cap_strobe), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  int nchk = 0, nfail = 0, cur = 0;
  int m_od = 0, m_id = 0, m_cap = 2;
  bit chk_mo = 0, mon_en = 0;
  bit mo_h [0:4095];
  bit mi_h [0:4095];
  int q_ks[$], q_cap[$], q_id[$];
  logic [15:0] lf = 16'hACE1;

  task automatic fail(input string req, input int act, input int exp);
    nfail++;
    $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cur);
  endtask

  function automatic logic [31:0] mk(input int od, input int id, input int cap);
    return (32'(od) << 16) | (32'(id) << 18) | (32'(cap) << 20);
  endfunction

  // driver: applies one cycle of stimulus and pushes expected capture items
  task automatic step(input logic b, input logic s);
    int exp;
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    burst_active = b; cap_strobe = s; mosi_core = lf[0]; miso_pin = lf[7];
    mo_h[cur] = lf[0]; mi_h[cur] = lf[7];
    if (s) begin q_ks.push_back(cur); q_cap.push_back(m_cap); q_id.push_back(m_id); end
    #1;
    if (chk_mo) begin
      nchk++;
      exp = (cur >= m_od) ? int'(mo_h[cur - m_od]) : 0;
      if (mosi_pin !== 1'(exp)) fail("R1 mosi delay", int'(mosi_pin), exp);
    end
    @(posedge clk);
    cur++;
  endtask

  // monitor: pops expected captures as valids appear
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      int e, ks, cp, id, expb;
      e = cur - 1;
      if (q_ks.size() > 0 && q_ks[0] + q_cap[0] < e) begin
        nchk++;
        fail("R5 missing valid", e, q_ks[0] + q_cap[0]);
        void'(q_ks.pop_front()); void'(q_cap.pop_front()); void'(q_id.pop_front());
      end
      if (rx_valid) begin
        if (q_ks.size() == 0) begin
          nchk++;
          fail("R5 valid without strobe", 1, 0);
        end else begin
          ks = q_ks.pop_front(); cp = q_cap.pop_front(); id = q_id.pop_front();
          nchk++;
          if (e != ks + cp) fail("R4 valid timing", e, ks + cp);
          expb = int'(mi_h[ks + cp - 2 - id]);
          nchk++;
          if (rx_bit !== 1'(expb)) fail("R2/R3 captured bit", int'(rx_bit), expb);
        end
      end
    end
  end

  int od_c[6]  = '{0, 1, 3, 2, 0, 3};
  int id_c[6]  = '{0, 2, 1, 3, 3, 0};
  int cap_c[6] = '{2, 0, 3, 1, 0, 2};

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cur, 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    mosi_core = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    nchk++; if (rx_valid !== 1'b0) fail("R7 rx_valid in reset", int'(rx_valid), 0);
    nchk++; if (rx_bit !== 1'b0) fail("R7 rx_bit in reset", int'(rx_bit), 0);
    nchk++; if (mosi_pin !== 1'b1) fail("R7 pass-through in reset", int'(mosi_pin), 1);
    mosi_core = 1'b0;
    rst_n = 1'b1;
    mon_en = 1;
    for (int i = 0; i < 6; i++) begin
      ctrl_word = mk(od_c[i], id_c[i], cap_c[i]);
      if (i == 4) ctrl_word = ctrl_word | ~32'h003F_0000; // R8: unrelated bits set
      repeat (3) step(1'b0, 1'b0);
      m_od = od_c[i]; m_id = id_c[i]; m_cap = cap_c[i];
      chk_mo = 1;
      for (int j = 0; j < 40; j++) begin
        if (i == 2 && j == 15) ctrl_word = mk(od_c[3], id_c[3], cap_c[3]); // R6 hold
        step(1'b1, (j >= 6 && j <= 33) && (j % 3 == 0 || j == 20 || j == 22));
      end
      chk_mo = 0;
      repeat (6) step(1'b0, 1'b0);
      nchk++;
      if (q_ks.size() != 0) fail("R5 strobes left unanswered", q_ks.size(), 0);
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule